// File: doc/BRIEF.md
# ATA Task-File Register and Interrupt Gate

This block holds the host-visible register set of one ATA disk device and owns its interrupt request line. A host reaches it through a byte-wide register port with two chip selects, one for the command block and one for the control block. Address registers (sector number, both cylinder bytes and device/head) read back what the host last wrote, or what the device's address sequencer last loaded. The device control register carries the interrupt-disable bit.

The device keeps an internal interrupt-pending flag. The line seen by the host is that flag, gated by device selection and by the interrupt-disable bit. Because the gate is evaluated from the stored registers, a write to device/head or to device control changes the line right away, while the pending flag itself is kept. A command write is handed to an external command engine through a one-cycle start pulse. Accepting a command clears the pending flag, the DMA request and the error bit in status. The engine answers with an acknowledge that may flag the code as unsupported. The block then reports an aborted command on its own.

Top module: `ata_taskfile_irq`

## Requirements
- R1: After reset the status register reads 0x10 (DSC, bit 4), or 0x50 when dev_ready is high at reset (DRDY, bit 6, added). intrq and dmarq are low, and the error register (command block address 1) reads 0x01.
- R2: intrq is high only while the pending flag is set, bit 4 of device/head equals dev_num and bit 1 of device control (control block address 6) is 0. A write to either register takes effect on intrq in the cycle after the write, and a masked pending flag drives intrq again once it is unmasked.
- R3: A write to the command register (command block address 7) starts a command (cmd_start pulses for one cycle with cmd_code equal to the written code) only when the device is selected or the code is 0x90. The 0x90 code is accepted even when the device is not selected.
- R4: Accepting a command clears the pending flag, dmarq and the ERR status bit (bit 0). These clears take priority over set requests arriving in the same cycle.
- R5: An engine acknowledge that reports the code as unsupported sets ERR, loads the error register with 0x04 and sets the pending flag.
- R6: Sector number (address 3), cylinder low (4), cylinder high (5) and device/head (6) in the command block read back the last byte written.
- R7: Reading status (command block address 7) clears the pending flag, unless a set request arrives in the same cycle. Reading alternate status (control block address 6) returns status and leaves the pending flag alone.
- R8: A status read with dev_ready high sets DRDY, and the value returned by that read already includes it. An alternate-status read does not set DRDY.
- R9: An eng_irq pulse sets the pending flag, and an eng_dmarq pulse raises dmarq until the next accepted command.
- R10: An eng_addr_ld pulse loads sector number from eng_addr[7:0], cylinder low from [15:8], cylinder high from [23:16] and device/head bits 3:0 from [27:24]. Device/head bits 7:4 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_num | input | 1 | Static device number, 0 or 1 |
| dev_ready | input | 1 | Device is ready to accept commands |
| host_cs_cmd | input | 1 | Command-block select |
| host_cs_ctl | input | 1 | Control-block select |
| host_addr | input | 3 | Register address within the selected block |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after host_rd |
| intrq | output | 1 | Gated interrupt request |
| dmarq | output | 1 | DMA request |
| cmd_start | output | 1 | One-cycle pulse: accepted command, reset buffer pointer and countdown |
| cmd_code | output | 8 | Last command code written |
| eng_ack | input | 1 | Engine acknowledges the started command |
| eng_unsup | input | 1 | With eng_ack: code is not supported |
| eng_irq | input | 1 | Engine requests an interrupt |
| eng_dmarq | input | 1 | Engine raises the DMA request |
| eng_addr_ld | input | 1 | Address sequencer load strobe |
| eng_addr | input | 28 | Sequencer address: head, cylinder high, cylinder low, sector |

## Verification
The gate is driven through each of its three inputs in turn: masking with the disable bit, deselecting through device/head, and restoring each. A line that comes back after unmasking shows the flag was kept rather than cleared. Commands are written while selected, while deselected with an ordinary code and while deselected with 0x90. This separates the selection rule from the diagnostic exception, and a supported code and an unsupported code separate the abort path from normal completion. Status and alternate-status reads are interleaved with a pending interrupt and a late dev_ready to tell the clearing read from the passive one.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  // command-block addresses
  localparam logic [AW-1:0] A_ERROR  = 3'd1;
  localparam logic [AW-1:0] A_SECNUM = 3'd3;
  localparam logic [AW-1:0] A_CYLLO  = 3'd4;
  localparam logic [AW-1:0] A_CYLHI  = 3'd5;
  localparam logic [AW-1:0] A_DEVHD  = 3'd6;
  localparam logic [AW-1:0] A_CMDST  = 3'd7;
  // control-block address
  localparam logic [AW-1:0] A_CTLALT = 3'd6;
  // bit positions
  localparam int ST_DRDY  = 6;
  localparam int ST_DSC   = 4;
  localparam int ST_ERR   = 0;
  localparam int DH_DEV   = 4;
  localparam int DC_NIEN  = 1;
  // codes
  localparam logic [DW-1:0] CODE_DIAG   = 8'h90;
  localparam logic [DW-1:0] ERRV_ABORT  = 8'h04;
  localparam logic [DW-1:0] ERRV_RESET  = 8'h01;
endpackage

// File: rtl/tf_regs.sv
module tf_regs
  import ata_tf_pkg::*;
#(
  parameter int W = DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_sn,
  input  logic           wr_cl,
  input  logic           wr_ch,
  input  logic           wr_dh,
  input  logic           wr_dc,
  input  logic [W-1:0]   wdata,
  input  logic           ld_i,
  input  logic [4*W-5:0] ld_addr,
  input  logic           dev_num,
  output logic [W-1:0]   sn_o,
  output logic [W-1:0]   cl_o,
  output logic [W-1:0]   ch_o,
  output logic [W-1:0]   dh_o,
  output logic           dev_sel_o,
  output logic           nien_o
);
  localparam int HB = 4;  // head field width inside device/head
  logic [W-1:0] sn_q, cl_q, ch_q, dh_q, dc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sn_q <= '0;
      cl_q <= '0;
      ch_q <= '0;
      dh_q <= '0;
      dc_q <= '0;
    end else begin
      // host writes take priority over sequencer loads
      if (wr_sn) sn_q <= wdata;
      else if (ld_i) sn_q <= ld_addr[W-1:0];
      if (wr_cl) cl_q <= wdata;
      else if (ld_i) cl_q <= ld_addr[2*W-1:W];
      if (wr_ch) ch_q <= wdata;
      else if (ld_i) ch_q <= ld_addr[3*W-1:2*W];
      if (wr_dh) dh_q <= wdata;
      else if (ld_i) dh_q[HB-1:0] <= ld_addr[3*W+HB-1:3*W];
      if (wr_dc) dc_q <= wdata;
    end
  end

  assign sn_o      = sn_q;
  assign cl_o      = cl_q;
  assign ch_o      = ch_q;
  assign dh_o      = dh_q;
  assign dev_sel_o = (dh_q[DH_DEV] == dev_num);
  assign nien_o    = dc_q[DC_NIEN];

  // sequencer load never disturbs the upper device/head bits
  assert_seq_keeps_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !wr_dh) |=> (dh_q[W-1:HB] == $past(dh_q[W-1:HB])));
endmodule

// File: rtl/tf_irq.sv
module tf_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_cmd_i,
  input  logic clr_rd_i,
  input  logic sel_i,
  input  logic nien_i,
  output logic intrq_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (clr_cmd_i) pend_q <= 1'b0;   // command acceptance wins
    else if (set_i)     pend_q <= 1'b1;   // set beats a status read
    else if (clr_rd_i)  pend_q <= 1'b0;
  end

  assign intrq_o = pend_q & sel_i & ~nien_i;

  assert_masked_keeps_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_cmd_i && !clr_rd_i) |=> pend_q);
endmodule

// File: rtl/tf_cmd.sv
module tf_cmd
  import ata_tf_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_wr,
  input  logic [W-1:0] wdata,
  input  logic         dev_sel,
  input  logic         stat_rd,
  input  logic         dev_ready,
  input  logic         eng_ack,
  input  logic         eng_unsup,
  input  logic         eng_dmarq,
  output logic         accept_o,
  output logic         abort_o,
  output logic         cmd_start_o,
  output logic [W-1:0] cmd_code_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] status_rd_o,
  output logic [W-1:0] error_o,
  output logic         dmarq_o
);
  logic         drdy_q, err_q, start_q, dmarq_q;
  logic [W-1:0] errreg_q, code_q;

  assign accept_o = cmd_wr & (dev_sel | (wdata == CODE_DIAG));
  assign abort_o  = eng_ack & eng_unsup;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_q   <= dev_ready;
      err_q    <= 1'b0;
      start_q  <= 1'b0;
      dmarq_q  <= 1'b0;
      errreg_q <= ERRV_RESET;
      code_q   <= '0;
    end else begin
      start_q <= accept_o;
      if (cmd_wr) code_q <= wdata;
      if (stat_rd && dev_ready) drdy_q <= 1'b1;
      if (accept_o)     err_q <= 1'b0;
      else if (abort_o) err_q <= 1'b1;
      if (abort_o && !accept_o) errreg_q <= ERRV_ABORT;
      if (accept_o)       dmarq_q <= 1'b0;
      else if (eng_dmarq) dmarq_q <= 1'b1;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_DSC]  = 1'b1;
    status_o[ST_DRDY] = drdy_q;
    status_o[ST_ERR]  = err_q;
    status_rd_o       = status_o;
    if (dev_ready) status_rd_o[ST_DRDY] = 1'b1;
  end

  assign cmd_start_o = start_q;
  assign cmd_code_o  = code_q;
  assign error_o     = errreg_q;
  assign dmarq_o     = dmarq_q;

  assert_abort_reports_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_ack && eng_unsup && !cmd_wr) |=> (status_o[ST_ERR] && error_o == ERRV_ABORT));
  assert_drdy_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && dev_ready) |=> status_o[ST_DRDY]);
endmodule

// File: rtl/ata_taskfile_irq.sv
module ata_taskfile_irq
  import ata_tf_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dev_num,
  input  logic           dev_ready,
  input  logic           host_cs_cmd,
  input  logic           host_cs_ctl,
  input  logic [A-1:0]   host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [W-1:0]   host_wdata,
  output logic [W-1:0]   host_rdata,
  output logic           intrq,
  output logic           dmarq,
  output logic           cmd_start,
  output logic [W-1:0]   cmd_code,
  input  logic           eng_ack,
  input  logic           eng_unsup,
  input  logic           eng_irq,
  input  logic           eng_dmarq,
  input  logic           eng_addr_ld,
  input  logic [4*W-5:0] eng_addr
);
  logic cw, cr, kw, kr;
  assign cw = host_wr & host_cs_cmd & ~host_cs_ctl;
  assign cr = host_rd & host_cs_cmd & ~host_cs_ctl;
  assign kw = host_wr & host_cs_ctl & ~host_cs_cmd;
  assign kr = host_rd & host_cs_ctl & ~host_cs_cmd;

  logic [W-1:0] sn, cl, ch, dh, st, st_rd, errv;
  logic sel, nien, accept, abort, stat_rd;

  assign stat_rd = cr && (host_addr == A_CMDST);

  tf_regs #(.W(W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_sn(cw && host_addr == A_SECNUM),
    .wr_cl(cw && host_addr == A_CYLLO),
    .wr_ch(cw && host_addr == A_CYLHI),
    .wr_dh(cw && host_addr == A_DEVHD),
    .wr_dc(kw && host_addr == A_CTLALT),
    .wdata(host_wdata), .ld_i(eng_addr_ld), .ld_addr(eng_addr),
    .dev_num(dev_num),
    .sn_o(sn), .cl_o(cl), .ch_o(ch), .dh_o(dh),
    .dev_sel_o(sel), .nien_o(nien)
  );

  tf_cmd #(.W(W)) cmd_i (
    .clk(clk), .rst(rst),
    .cmd_wr(cw && host_addr == A_CMDST), .wdata(host_wdata),
    .dev_sel(sel), .stat_rd(stat_rd), .dev_ready(dev_ready),
    .eng_ack(eng_ack), .eng_unsup(eng_unsup), .eng_dmarq(eng_dmarq),
    .accept_o(accept), .abort_o(abort),
    .cmd_start_o(cmd_start), .cmd_code_o(cmd_code),
    .status_o(st), .status_rd_o(st_rd), .error_o(errv), .dmarq_o(dmarq)
  );

  tf_irq irq_i (
    .clk(clk), .rst(rst),
    .set_i(eng_irq | abort),
    .clr_cmd_i(accept),
    .clr_rd_i(stat_rd),
    .sel_i(sel), .nien_i(nien),
    .intrq_o(intrq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (cr) begin
      unique case (host_addr)
        A_ERROR:  host_rdata <= errv;
        A_SECNUM: host_rdata <= sn;
        A_CYLLO:  host_rdata <= cl;
        A_CYLHI:  host_rdata <= ch;
        A_DEVHD:  host_rdata <= dh;
        A_CMDST:  host_rdata <= st_rd;
        default:  host_rdata <= '0;
      endcase
    end else if (kr) begin
      host_rdata <= (host_addr == A_CTLALT) ? st : '0;
    end
  end

  assert_accept_clears_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (!intrq && !dmarq && !st[ST_ERR]));
  assert_accept_rule_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(cw && host_addr == A_CMDST && (sel || host_wdata == CODE_DIAG)));
  assert_nien_masks_R2: assert property (@(posedge clk) disable iff (rst)
    (kw && host_addr == A_CTLALT && host_wdata[DC_NIEN]) |=> !intrq);
  assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !eng_irq && !abort) |=> !intrq);
endmodule

// File: tb/ata_taskfile_irq_tb.sv
module ata_taskfile_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic dev_num = 1'b0, dev_ready = 1'b0;
  logic cs_cmd = 0, cs_ctl = 0, wr = 0, rd = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, cmd_code;
  logic intrq, dmarq, cmd_start;
  logic eng_ack = 0, eng_unsup = 0, tb_irq = 0, eng_dmarq = 0, eng_addr_ld = 0;
  logic [27:0] eng_addr = '0;
  logic mdl_irq = 0;

  int checks = 0, errors = 0, starts = 0;
  logic [7:0] last_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_irq dut_i (
    .clk(clk), .rst(rst), .dev_num(dev_num), .dev_ready(dev_ready),
    .host_cs_cmd(cs_cmd), .host_cs_ctl(cs_ctl), .host_addr(addr),
    .host_wr(wr), .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata),
    .intrq(intrq), .dmarq(dmarq), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .eng_ack(eng_ack), .eng_unsup(eng_unsup), .eng_irq(tb_irq | mdl_irq),
    .eng_dmarq(eng_dmarq), .eng_addr_ld(eng_addr_ld), .eng_addr(eng_addr)
  );

  // minimal command engine: acks one cycle after start
  function automatic bit supported(input logic [7:0] c);
    return (c == 8'h20) || (c == 8'h90) || (c == 8'hEC);
  endfunction
  always @(posedge clk) begin
    eng_ack   <= cmd_start;
    eng_unsup <= cmd_start && !supported(cmd_code);
    mdl_irq   <= cmd_start && supported(cmd_code);
    if (cmd_start) begin
      starts    <= starts + 1;
      last_code <= cmd_code;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input bit ctl, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic hrd(input bit ctl, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; rd = 1;
    @(negedge clk);
    rd = 0; cs_cmd = 0; cs_ctl = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1; idle(2); rst = 0; idle(1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    dev_ready = 0; do_reset();
    check(!intrq && !dmarq, "R1 lines", {intrq, dmarq}, 0);
    hrd(1, 3'd6, v); check(v == 8'h10, "R1 status not ready", v, 8'h10);
    hrd(0, 3'd1, v); check(v == 8'h01, "R1 error reg", v, 8'h01);
    dev_ready = 1; do_reset();
    hrd(1, 3'd6, v); check(v == 8'h50, "R1 status ready", v, 8'h50);
  endtask

  task automatic t_drdy;
    logic [7:0] v;
    dev_ready = 0; do_reset(); dev_ready = 1;
    hrd(1, 3'd6, v); check(v == 8'h10, "R8 alt read leaves DRDY", v, 8'h10);
    hrd(0, 3'd7, v); check(v == 8'h50, "R8 status read sets DRDY", v, 8'h50);
    hrd(1, 3'd6, v); check(v == 8'h50, "R8 DRDY kept", v, 8'h50);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    hwr(0, 3'd3, 8'h5A); hwr(0, 3'd4, 8'hC3); hwr(0, 3'd5, 8'h81); hwr(0, 3'd6, 8'hE2);
    hrd(0, 3'd3, v); check(v == 8'h5A, "R6 sector", v, 8'h5A);
    hrd(0, 3'd4, v); check(v == 8'hC3, "R6 cyl low", v, 8'hC3);
    hrd(0, 3'd5, v); check(v == 8'h81, "R6 cyl high", v, 8'h81);
    hrd(0, 3'd6, v); check(v == 8'hE2, "R6 dev/head", v, 8'hE2);
  endtask

  task automatic t_seq;
    logic [7:0] v;
    hwr(0, 3'd6, 8'hE0);
    @(negedge clk); eng_addr = 28'hABBCCDD; eng_addr_ld = 1;
    @(negedge clk); eng_addr_ld = 0;
    hrd(0, 3'd3, v); check(v == 8'hDD, "R10 sector", v, 8'hDD);
    hrd(0, 3'd4, v); check(v == 8'hCC, "R10 cyl low", v, 8'hCC);
    hrd(0, 3'd5, v); check(v == 8'hBB, "R10 cyl high", v, 8'hBB);
    hrd(0, 3'd6, v); check(v == 8'hEA, "R10 dev/head", v, 8'hEA);
    hwr(0, 3'd6, 8'h00);
  endtask

  task automatic t_gating;
    logic [7:0] v;
    hwr(0, 3'd6, 8'h00); hwr(1, 3'd6, 8'h00);
    hwr(0, 3'd7, 8'h20); idle(3);
    check(intrq, "R9 engine irq raises intrq", intrq, 1);
    hwr(1, 3'd6, 8'h02); check(!intrq, "R2 nIEN masks", intrq, 0);
    hwr(1, 3'd6, 8'h00); check(intrq, "R2 unmask restores", intrq, 1);
    hwr(0, 3'd6, 8'h10); check(!intrq, "R2 deselect masks", intrq, 0);
    hwr(0, 3'd6, 8'h00); check(intrq, "R2 reselect restores", intrq, 1);
    hrd(1, 3'd6, v); check(intrq, "R7 alt read keeps flag", intrq, 1);
    hrd(0, 3'd7, v); check(!intrq, "R7 status read clears", intrq, 0);
    check(v == 8'h50, "R7 status value", v, 8'h50);
  endtask

  task automatic t_accept;
    int s0;
    logic [7:0] v;
    hwr(0, 3'd6, 8'h10); s0 = starts;
    hwr(0, 3'd7, 8'h20); idle(3);
    check(starts == s0, "R3 deselected command ignored", starts - s0, 0);
    hwr(0, 3'd6, 8'h00);
    check(!intrq, "R3 no interrupt from ignored command", intrq, 0);
    hwr(0, 3'd6, 8'h10);
    hwr(0, 3'd7, 8'h90); idle(3);
    check(starts == s0 + 1, "R3 diagnostic accepted deselected", starts - s0, 1);
    check(last_code == 8'h90, "R3 code passed", last_code, 8'h90);
    hwr(0, 3'd6, 8'h00);
    check(intrq, "R9 diagnostic completion", intrq, 1);
    hrd(0, 3'd7, v);
  endtask

  task automatic t_unsup;
    logic [7:0] v;
    hwr(0, 3'd7, 8'h77); idle(3);
    check(intrq, "R5 abort interrupt", intrq, 1);
    hrd(0, 3'd1, v); check(v == 8'h04, "R5 error code", v, 8'h04);
    hrd(0, 3'd7, v); check(v == 8'h51, "R5 ERR set", v, 8'h51);
    hwr(0, 3'd7, 8'hEC); idle(3);
    hrd(1, 3'd6, v); check(v == 8'h50, "R4 ERR cleared", v, 8'h50);
    hrd(0, 3'd7, v);
  endtask

  task automatic t_dma;
    @(negedge clk); eng_dmarq = 1; tb_irq = 1;
    @(negedge clk); eng_dmarq = 0; tb_irq = 0;
    check(dmarq, "R9 dmarq raised", dmarq, 1);
    check(intrq, "R9 pending set", intrq, 1);
    hwr(0, 3'd7, 8'h20);
    check(cmd_start, "R4 start pulse", cmd_start, 1);
    check(!dmarq && !intrq, "R4 accept clears", {dmarq, intrq}, 0);
    idle(1);
    check(!cmd_start, "R4 pulse one cycle", cmd_start, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_drdy();
    t_readback();
    t_seq();
    t_gating();
    t_accept();
    t_unsup();
    t_dma();
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule